// File: doc/BRIEF.md
# Power-Up Recall Supervisor

This block watches the supply of a nonvolatile SRAM through three digital comparator flags: supply above the reset level, above the store level and above the switch level. It decides when the memory sequencer must copy the nonvolatile image back into the SRAM, when ordinary reads and writes may go ahead, and when STORE operations must be refused. The analog comparators are outside the block. Each flag arrives asynchronously, is synchronised, and is accepted only after it has held its new value for a set number of cycles.

A recall is armed at power-up and again whenever the supply falls below the reset level. When the supply climbs back over the switch level, one single-cycle recall request goes to the sequencer, and access stays blocked for a restore window. Access is also blocked until the sequencer reports that the recall has finished. A shallow dip, where the supply stays above the reset level but drops below the switch level, blocks access and inhibits STOREs. On recovery it runs the restore window again but issues no recall.

Top module: `pwrup_recall_sup`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `recall_req` is 0, `access_ready` is 0 and `store_inhibit` is 1.
- R2: A change on any supply flag is ignored unless the flag holds its new value for FILT_CYCLES consecutive cycles after the two-flop synchroniser. A pulse of 2 cycles with FILT_CYCLES=4 changes no output.
- R3: Each accepted rise of the switch flag while a recall is armed gives exactly one `recall_req` pulse, and that pulse is one cycle wide.
- R4: `access_ready` rises only after the switch flag has been accepted high for at least RESTORE_CYCLES cycles and no recall is still outstanding. With an armed recall it stays low until `recall_done` is seen.
- R5: `store_inhibit` is 1 exactly while the accepted store flag is low (supply under the store level).
- R6: A dip below the switch level that stays above the reset level drops `access_ready` and raises `store_inhibit` if the store flag falls. On recovery no `recall_req` is issued, and `access_ready` returns after the restore window.
- R7: An accepted fall of the reset flag re-arms the recall, so that the next recovery above the switch level issues `recall_req` and waits for `recall_done`.
- R8: `recall_done` pulsed while no recall request is outstanding has no effect: the armed recall still blocks `access_ready` after the restore window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_above_rst | input | 1 | Asynchronous flag: supply above the reset level |
| sup_above_store | input | 1 | Asynchronous flag: supply above the store level |
| sup_above_switch | input | 1 | Asynchronous flag: supply above the switch level |
| recall_done | input | 1 | Sequencer reports that the recall has finished |
| recall_req | output | 1 | One-cycle request to start a recall |
| access_ready | output | 1 | Normal SRAM access allowed |
| store_inhibit | output | 1 | STORE operations must be refused |

## Verification
The assertions assume that the three flags follow the physical ordering of the thresholds. The switch flag is high only when the store flag is high, and the store flag is high only when the reset flag is high. The bench therefore raises the flags from the lowest level upward and drops them from the switch level downward, with a gap of ten cycles between steps so that each step is filtered before the next. The assertions also assume that `recall_done` is a short pulse. The bench drives it for a single cycle, once before any request is outstanding and once after each issued request.

// File: rtl/psup_pkg.sv
// Package: shared constants and state encoding for the power-up recall supervisor.
// Assumes: flag indices are used to pick filter instances in a generate loop.
package psup_pkg;
    localparam int NUM_FLAGS  = 3;
    localparam int FLG_RST    = 0;
    localparam int FLG_STORE  = 1;
    localparam int FLG_SWITCH = 2;

    typedef enum logic [1:0] {
        SUP_LOW     = 2'd0,
        SUP_RESTORE = 2'd1,
        SUP_READY   = 2'd2
    } sup_state_e;
endpackage

// File: rtl/psup_flag_filter.sv
// Module: synchronises one asynchronous comparator flag and accepts a new
// level only after it has been stable for FILT_CYCLES cycles.
// Assumes: FILT_CYCLES >= 1; the accepted level resets to 0 (supply low).
module psup_flag_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_CYCLES) + 1;

    logic          sync1, sync2;
    logic [CW-1:0] stable_cnt;

    // Two-flop synchroniser for the asynchronous flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Stability counter: adopt the synchronised level after FILT_CYCLES differing cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt       <= 1'b0;
            stable_cnt <= '0;
        end else if (sync2 == filt) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CW'(FILT_CYCLES - 1)) begin
            filt       <= sync2;
            stable_cnt <= '0;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psup_recall_arm.sv
// Module: holds the armed-recall latch and the outstanding-request flag.
// Assumes: deep_low is the accepted "below reset level" condition; the latch
// is armed out of reset (power-up) and clears only on recall_done.
module psup_recall_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic deep_low,
    input  logic issue,
    input  logic recall_done,
    output logic armed,
    output logic issued
);
    // Arm on deep supply loss, mark a request outstanding, clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b1;
            issued <= 1'b0;
        end else if (deep_low) begin
            armed  <= 1'b1;
            issued <= 1'b0;
        end else if (issued && recall_done) begin
            armed  <= 1'b0;
            issued <= 1'b0;
        end else if (issue) begin
            issued <= 1'b1;
        end
    end
endmodule

// File: rtl/psup_restore_timer.sv
// Module: tracks the accepted switch flag, times the restore window after
// each rise and grants access once the window ends and no recall is pending.
// Assumes: RESTORE_CYCLES >= 2; a fall of the switch flag aborts the window.
module psup_restore_timer
    import psup_pkg::*;
#(
    parameter int RESTORE_CYCLES = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_ok,
    input  logic armed,
    output logic sw_rise,
    output logic ready
);
    localparam int TW = $clog2(RESTORE_CYCLES) + 1;

    sup_state_e    state;
    logic          sw_prev;
    logic [TW-1:0] win_cnt;

    assign sw_rise = sw_ok & ~sw_prev;
    assign ready   = (state == SUP_READY);

    // Edge detector history for the accepted switch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_prev <= 1'b0;
        else        sw_prev <= sw_ok;
    end

    // Supply state machine: low, restore window, ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SUP_LOW;
            win_cnt <= '0;
        end else begin
            case (state)
                SUP_LOW: begin
                    if (sw_rise) begin
                        state   <= SUP_RESTORE;
                        win_cnt <= '0;
                    end
                end
                SUP_RESTORE: begin
                    if (!sw_ok) begin
                        state <= SUP_LOW;
                    end else if (win_cnt != TW'(RESTORE_CYCLES - 1)) begin
                        win_cnt <= win_cnt + 1'b1;
                    end else if (!armed) begin
                        state <= SUP_READY;
                    end
                end
                SUP_READY: begin
                    if (!sw_ok) state <= SUP_LOW;
                end
                default: state <= SUP_LOW;
            endcase
        end
    end
endmodule

// File: rtl/pwrup_recall_sup.sv
// Module: top of the power-up recall supervisor. Filters three supply flags,
// arms a recall on power-up or deep loss, issues one recall request per
// recovery and gates normal access and STOREs.
// Assumes: flags obey reset <= store <= switch ordering of the thresholds.
module pwrup_recall_sup
    import psup_pkg::*;
#(
    parameter int FILT_CYCLES    = 4,
    parameter int RESTORE_CYCLES = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_rst,
    input  logic sup_above_store,
    input  logic sup_above_switch,
    input  logic recall_done,
    output logic recall_req,
    output logic access_ready,
    output logic store_inhibit
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] acc_flags;
    logic                 sw_rise, armed, issued, issue, ready;
    logic                 req_q;

    assign raw_flags[FLG_RST]    = sup_above_rst;
    assign raw_flags[FLG_STORE]  = sup_above_store;
    assign raw_flags[FLG_SWITCH] = sup_above_switch;

    // One synchroniser and stability filter per comparator flag.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        psup_flag_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flags[g]),
            .filt (acc_flags[g])
        );
    end

    assign issue = sw_rise & armed & ~issued;

    psup_recall_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .deep_low   (~acc_flags[FLG_RST]),
        .issue      (issue),
        .recall_done(recall_done),
        .armed      (armed),
        .issued     (issued)
    );

    psup_restore_timer #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_ok  (acc_flags[FLG_SWITCH]),
        .armed  (armed),
        .sw_rise(sw_rise),
        .ready  (ready)
    );

    // Register the recall request so it leaves the block as a clean pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= issue;
    end

    assign recall_req    = req_q;
    assign access_ready  = ready;
    assign store_inhibit = ~acc_flags[FLG_STORE];
endmodule

// File: rtl/pwrup_recall_sup_checker.sv
// Module: assertion checker for the power-up recall supervisor, bound to the top.
// Assumes: supply flags keep the threshold ordering (see brief).
module pwrup_recall_sup_checker #(
    parameter int RESTORE_CYCLES = 27500
) (
    input logic clk,
    input logic rst_n,
    input logic recall_req,
    input logic access_ready,
    input logic store_inhibit
);
    localparam int LW = $clog2(RESTORE_CYCLES + 2) + 1;

    logic [LW-1:0] low_cnt;

    // Count consecutive cycles with access blocked, saturating past the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                low_cnt <= '0;
        else if (access_ready)                     low_cnt <= '0;
        else if (low_cnt != LW'(RESTORE_CYCLES + 1)) low_cnt <= low_cnt + 1'b1;
    end

    assert_req_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    assert_no_ready_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> !access_ready);

    assert_ready_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ready) |-> (low_cnt >= LW'(RESTORE_CYCLES)));

    assert_ready_no_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        access_ready |-> !store_inhibit);

    assert_req_needs_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> !store_inhibit);
endmodule

bind pwrup_recall_sup pwrup_recall_sup_checker #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .recall_req   (recall_req),
    .access_ready (access_ready),
    .store_inhibit(store_inhibit)
);

// File: tb/pwrup_recall_sup_bench.sv
// Bench: scoreboard of expected output events for the recall supervisor.
// A driver pushes expected events; a monitor pops them as outputs change.
module pwrup_recall_sup_bench;
    localparam int FILT    = 4;
    localparam int RESTORE = 20;

    localparam int EV_REQ   = 0;
    localparam int EV_RDY_U = 1;
    localparam int EV_RDY_D = 2;
    localparam int EV_INH_U = 3;
    localparam int EV_INH_D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_rst = 1'b0, f_store = 1'b0, f_sw = 1'b0, done = 1'b0;
    logic req, rdy, inh;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    logic p_req, p_rdy, p_inh;

    always #10 clk = ~clk;

    pwrup_recall_sup #(.FILT_CYCLES(FILT), .RESTORE_CYCLES(RESTORE)) u_pwrup_recall_sup (
        .clk(clk), .rst_n(rst_n),
        .sup_above_rst(f_rst), .sup_above_store(f_store), .sup_above_switch(f_sw),
        .recall_done(done),
        .recall_req(req), .access_ready(rdy), .store_inhibit(inh)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int ev);
        exp_q.push_back(ev);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_done();
        done = 1'b1;
        cyc(1);
        done = 1'b0;
    endtask

    task automatic pop_cmp(input int act, input string tag);
        int e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s: actual event %0d expected none", tag, act);
        end else begin
            e = exp_q.pop_front();
            if (e != act) begin
                fails++;
                $display("FAIL %s: actual event %0d expected %0d", tag, act, e);
            end
        end
    endtask

    // Monitor: turn output changes into events and match them against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (req && !p_req)  pop_cmp(EV_REQ,   "R3/R7 recall_req");
            if (req && p_req)   chk("R3 recall_req one cycle", 1'b1, 1'b0);
            if (rdy && !p_rdy)  pop_cmp(EV_RDY_U, "R4/R6 access_ready rise");
            if (!rdy && p_rdy)  pop_cmp(EV_RDY_D, "R6 access_ready fall");
            if (inh && !p_inh)  pop_cmp(EV_INH_U, "R5 store_inhibit rise");
            if (!inh && p_inh)  pop_cmp(EV_INH_D, "R5 store_inhibit fall");
        end
        p_req = req;
        p_rdy = rdy;
        p_inh = inh;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        p_req = 1'b0; p_rdy = 1'b0; p_inh = 1'b1;
        cyc(3);
        // R1: outputs while reset is held.
        chk("R1 recall_req in reset", req, 1'b0);
        chk("R1 access_ready in reset", rdy, 1'b0);
        chk("R1 store_inhibit in reset", inh, 1'b1);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 access_ready after reset", rdy, 1'b0);

        // R8: completion pulse with nothing outstanding is ignored.
        pulse_done();

        // Power-up: raise levels from the bottom.
        f_rst = 1'b1; cyc(10);
        expect_ev(EV_INH_D);
        f_store = 1'b1; cyc(10);
        chk("R5 store_inhibit low above store level", inh, 1'b0);
        expect_ev(EV_REQ);
        f_sw = 1'b1; cyc(15);
        chk("R4 access blocked inside window", rdy, 1'b0);
        cyc(30);
        chk("R8 stray done ignored, access still blocked", rdy, 1'b0);
        expect_ev(EV_RDY_U);
        pulse_done(); cyc(3);
        chk("R4 access granted after done", rdy, 1'b1);

        // R2: short glitch on the store flag must not move any output.
        f_store = 1'b0; cyc(2);
        f_store = 1'b1; cyc(12);
        chk("R2 glitch ignored store_inhibit", inh, 1'b0);
        chk("R2 glitch ignored access_ready", rdy, 1'b1);

        // R6: shallow dip, reset flag stays high.
        expect_ev(EV_RDY_D);
        f_sw = 1'b0; cyc(10);
        expect_ev(EV_INH_U);
        f_store = 1'b0; cyc(10);
        chk("R6 access dropped in shallow dip", rdy, 1'b0);
        chk("R5 store_inhibit in dip", inh, 1'b1);
        expect_ev(EV_INH_D);
        f_store = 1'b1; cyc(10);
        expect_ev(EV_RDY_U);
        f_sw = 1'b1; cyc(15);
        chk("R6 access blocked in restore window", rdy, 1'b0);
        cyc(25);
        chk("R6 access back without recall", rdy, 1'b1);

        // R7: deep dip below reset level re-arms the recall.
        expect_ev(EV_RDY_D);
        f_sw = 1'b0; cyc(10);
        expect_ev(EV_INH_U);
        f_store = 1'b0; cyc(10);
        f_rst = 1'b0; cyc(10);
        f_rst = 1'b1; cyc(10);
        expect_ev(EV_INH_D);
        f_store = 1'b1; cyc(10);
        expect_ev(EV_REQ);
        f_sw = 1'b1; cyc(45);
        chk("R7 access waits for recall after deep dip", rdy, 1'b0);
        expect_ev(EV_RDY_U);
        pulse_done(); cyc(3);
        chk("R7 access after recall completes", rdy, 1'b1);

        cyc(5);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R3/R6 scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule